// File: doc/BRIEF.md
# Packed Float/Int16 Conversion Unit

This block is a single-stage datapath that takes a 64-bit operand made of two 32-bit lanes and applies one of three operations, picked by a 2-bit opcode. The first turns each IEEE-754 single-precision lane into a signed 16-bit integer. The integer is clamped to the 16-bit range and then placed in a 32-bit lane. The second reads a signed 16-bit integer from the low half of each lane and writes the exactly equal single-precision value. The third permutes the operand. It can reverse the four 16-bit words, or it can exchange the two 32-bit halves.

Two plain mode inputs shape the result. `in_sign_ext` picks how the upper half of each float-to-integer lane is filled: with the sign of the 16-bit result, or with zeros. `in_dword_swap` picks the granularity of the permute. Both modes and the opcode are captured with the operand in the same transfer.

Operands arrive on a valid/ready stream and results leave on another. A transfer happens on a rising clock edge where valid and ready are both high. The result of an accepted operand is presented one cycle later. Back-pressure passes straight through: the unit accepts a new operand only when its output register is empty or is being drained in the same cycle. A stalled result keeps its value until it is taken.

Top module: `pk_cvt_unit`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An operand accepted on one edge appears on `out_data` with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R2: While `rst_n` is low, `out_valid` is low and `in_ready` is high.
- R3: Opcode 0 (float to int16) clamps each lane. A value of 2^15 or more, including +infinity, gives 0x7FFF. A value of -2^15 or less, including -infinity, gives 0x8000.
- R4: Opcode 0 truncates in-range values toward zero. Zero, denormals and any magnitude below 1.0 give 0.
- R5: Opcode 0 turns a NaN lane (exponent all ones, fraction non-zero) into 0x8000.
- R6: Opcode 0 puts the 16-bit results in output bits 15..0 (from source bits 31..0) and 47..32 (from source bits 63..32). With `in_sign_ext` = 0, bits 31..16 and 63..48 are zero.
- R7: Opcode 0 with `in_sign_ext` = 1 copies bit 15 of each 16-bit result across bits 31..16 of its lane.
- R8: Opcode 1 (int16 to float) converts signed source bits 15..0 exactly into output bits 31..0, and signed source bits 47..32 into output bits 63..32. Source bits 31..16 and 63..48 are ignored, and an input of 0 gives +0.0 (0x00000000).
- R9: Opcode 2 with `in_dword_swap` = 0 reverses the four 16-bit words: output word k = source word 3-k, where word k is bits 16k+15..16k.
- R10: Opcode 2 with `in_dword_swap` = 1 exchanges the 32-bit halves: output bits 63..32 = source bits 31..0, and output bits 31..0 = source bits 63..32.
- R11: Opcode 3 is reserved and produces an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Unit can accept an operand |
| in_data | input | 64 | Packed source operand |
| in_op | input | 2 | 0 float to int16, 1 int16 to float, 2 permute, 3 reserved |
| in_sign_ext | input | 1 | 1: sign-extend int16 results across the lane; 0: zero-fill |
| in_dword_swap | input | 1 | 1: exchange 32-bit halves; 0: reverse 16-bit words |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Packed result |

## Verification
The bound checker remembers each accepted operand and its modes. On every cycle it checks that a stalled result holds, that the unit stays idle in reset, how the upper lane halves are filled in both extension modes, clamping of large positive lanes, NaN handling, both permute granularities, the reserved opcode, and integer zero converting to +0.0. Exact truncation near ±2^15 and ±(2^15-1), fractional values next to those limits, infinities, denormals, and exact int16-to-float values at the range ends can only be shown by the bench's scenarios. The bench compares each of these against its behavioural model on every clock, while back-pressure patterns vary.

// File: rtl/pk_cvt_pkg.sv
package pk_cvt_pkg;
  localparam int FLT_W  = 32;
  localparam int INT_W  = 16;
  localparam int LANES  = 2;
  localparam int DATA_W = FLT_W * LANES;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = FLT_W - EXP_W - 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  typedef enum logic [1:0] {
    OP_F2I  = 2'd0,
    OP_I2F  = 2'd1,
    OP_SWAP = 2'd2,
    OP_RSVD = 2'd3
  } cvt_op_e;
endpackage

// File: rtl/pk_f2i_lane.sv
module pk_f2i_lane
  import pk_cvt_pkg::*;
(
  input  logic [FLT_W-1:0] flt,
  output logic [INT_W-1:0] ival
);
  localparam int SAT_EXP = BIAS + INT_W - 1;  // magnitude >= 2^15
  localparam int ALIGN   = BIAS + MAN_W;      // exponent where LSB weight is 1

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] fr;
  logic [MAN_W:0]   mant;
  logic [EXP_W-1:0] rsh;
  logic [INT_W-1:0] mag;

  assign sgn  = flt[FLT_W-1];
  assign ex   = flt[FLT_W-2 -: EXP_W];
  assign fr   = flt[MAN_W-1:0];
  assign mant = {1'b1, fr};
  assign rsh  = EXP_W'(ALIGN) - ex;

  always_comb begin
    logic [MAN_W:0] shifted;
    shifted = mant >> rsh;
    mag     = shifted[INT_W-1:0];
    if (ex == {EXP_W{1'b1}}) begin
      if (fr != '0) ival = {1'b1, {(INT_W-1){1'b0}}};
      else          ival = sgn ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
    end else if (ex >= EXP_W'(SAT_EXP)) begin
      ival = sgn ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
    end else if (ex < EXP_W'(BIAS)) begin
      ival = '0;
    end else begin
      ival = sgn ? INT_W'(~mag + 1'b1) : mag;
    end
  end
endmodule

// File: rtl/pk_i2f_lane.sv
module pk_i2f_lane
  import pk_cvt_pkg::*;
(
  input  logic [INT_W-1:0] ival,
  output logic [FLT_W-1:0] flt
);
  localparam int PW = $clog2(INT_W);

  logic [INT_W-1:0] mag;
  logic [PW-1:0]    msb;
  logic [MAN_W:0]   norm;
  logic [EXP_W-1:0] ex;

  assign mag = ival[INT_W-1] ? INT_W'(~ival + 1'b1) : ival;

  always_comb begin
    msb = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) msb = PW'(i);
    end
  end

  assign norm = (MAN_W + 1)'(mag) << (MAN_W - int'(msb));
  assign ex   = EXP_W'(BIAS) + EXP_W'(msb);
  assign flt  = (mag == '0) ? '0 : {ival[INT_W-1], ex, norm[MAN_W-1:0]};
endmodule

// File: rtl/pk_swap.sv
module pk_swap
  import pk_cvt_pkg::*;
(
  input  logic [DATA_W-1:0] src,
  input  logic              dword,
  output logic [DATA_W-1:0] dst
);
  localparam int NW = DATA_W / INT_W;
  localparam int ND = DATA_W / FLT_W;

  logic [DATA_W-1:0] by_word;
  logic [DATA_W-1:0] by_dword;

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign by_word[w*INT_W +: INT_W] = src[(NW-1-w)*INT_W +: INT_W];
  end
  for (genvar d = 0; d < ND; d++) begin : g_dword
    assign by_dword[d*FLT_W +: FLT_W] = src[(ND-1-d)*FLT_W +: FLT_W];
  end

  assign dst = dword ? by_dword : by_word;
endmodule

// File: rtl/pk_cvt_unit.sv
module pk_cvt_unit
  import pk_cvt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        in_op,
  input  logic              in_sign_ext,
  input  logic              in_dword_swap,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int HI_W = FLT_W - INT_W;

  logic [DATA_W-1:0] f2i_res;
  logic [DATA_W-1:0] i2f_res;
  logic [DATA_W-1:0] swp_res;
  logic [DATA_W-1:0] nxt;
  cvt_op_e           op;

  assign op = cvt_op_e'(in_op);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [INT_W-1:0] iv;
    logic [FLT_W-1:0] fv;

    pk_f2i_lane u_f2i (.flt(in_data[l*FLT_W +: FLT_W]), .ival(iv));
    pk_i2f_lane u_i2f (.ival(in_data[l*FLT_W +: INT_W]), .flt(fv));

    assign f2i_res[l*FLT_W +: FLT_W] =
      {(in_sign_ext ? {HI_W{iv[INT_W-1]}} : {HI_W{1'b0}}), iv};
    assign i2f_res[l*FLT_W +: FLT_W] = fv;
  end

  pk_swap u_swap (.src(in_data), .dword(in_dword_swap), .dst(swp_res));

  always_comb begin
    unique case (op)
      OP_F2I:  nxt = f2i_res;
      OP_I2F:  nxt = i2f_res;
      OP_SWAP: nxt = swp_res;
      default: nxt = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= nxt;
    end
  end
endmodule

// File: rtl/pk_cvt_chk.sv
module pk_cvt_chk
  import pk_cvt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic [1:0]        in_op,
  input logic              in_sign_ext,
  input logic              in_dword_swap,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  logic [1:0]        c_op;
  logic              c_sx;
  logic              c_dw;
  logic [DATA_W-1:0] c_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_op  <= '0;
      c_sx  <= 1'b0;
      c_dw  <= 1'b0;
      c_src <= '0;
    end else if (in_valid && in_ready) begin
      c_op  <= in_op;
      c_sx  <= in_sign_ext;
      c_dw  <= in_dword_swap;
      c_src <= in_data;
    end
  end

  logic is_f2i, is_i2f, is_swp, is_rsv, lo_nan, lo_big;
  assign is_f2i = out_valid && c_op == OP_F2I;
  assign is_i2f = out_valid && c_op == OP_I2F;
  assign is_swp = out_valid && c_op == OP_SWAP;
  assign is_rsv = out_valid && c_op == OP_RSVD;
  assign lo_nan = c_src[30:23] == 8'hFF && c_src[22:0] != '0;
  assign lo_big = !c_src[31] && c_src[30:23] >= 8'd142 && !lo_nan;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_reset_idle_R2: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_sat_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_f2i && lo_big |-> out_data[15:0] == 16'h7FFF);

  assert_nan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_f2i && lo_nan |-> out_data[15:0] == 16'h8000);

  assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_f2i && !c_sx |-> out_data[31:16] == 16'h0 && out_data[63:48] == 16'h0);

  assert_sign_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_f2i && c_sx |-> out_data[31:16] == {16{out_data[15]}} &&
                       out_data[63:48] == {16{out_data[47]}});

  assert_int_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_i2f && c_src[15:0] == 16'h0 |-> out_data[31:0] == 32'h0);

  assert_word_rev_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_swp && !c_dw |-> out_data[15:0] == c_src[63:48] && out_data[63:48] == c_src[15:0]
                        && out_data[31:16] == c_src[47:32] && out_data[47:32] == c_src[31:16]);

  assert_half_xchg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_swp && c_dw |-> out_data[63:32] == c_src[31:0] && out_data[31:0] == c_src[63:32]);

  assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
    is_rsv |-> out_data == '0);
endmodule

bind pk_cvt_unit pk_cvt_chk chk_i (.*);

// File: tb/pk_cvt_unit_tb_top.sv
module pk_cvt_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [1:0]  in_op = '0;
  logic        in_sign_ext = 1'b0;
  logic        in_dword_swap = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  int    bp_mode = 0;
  bit    done = 1'b0;
  string cur_tag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  pk_cvt_unit dut_i (.*);

  // ---------------- reference model ----------------
  function automatic logic [15:0] ref_f2i(input logic [31:0] f);
    int  e;
    real r;
    int  iv;
    e = int'(f[30:23]);
    if (e == 255) return (f[22:0] != 0) ? 16'h8000 : (f[31] ? 16'h8000 : 16'h7FFF);
    if (e == 0) return 16'h0000;
    r = (1.0 + real'(f[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    if (f[31]) r = -r;
    if (r >= 32768.0) return 16'h7FFF;
    if (r <= -32768.0) return 16'h8000;
    iv = $rtoi(r);
    return iv[15:0];
  endfunction

  function automatic logic [31:0] ref_i2f(input logic [15:0] v);
    logic [63:0] d;
    logic [10:0] e11;
    if (v == 16'h0) return 32'h0;
    d   = $realtobits($itor($signed(v)));
    e11 = d[62:52] - 11'd896;
    return {d[63], e11[7:0], d[51:29]};
  endfunction

  function automatic logic [63:0] ref_op(input logic [1:0] op, input logic [63:0] s,
                                         input logic sx, input logic dw);
    logic [15:0] a, b;
    case (op)
      2'd0: begin
        a = ref_f2i(s[31:0]);
        b = ref_f2i(s[63:32]);
        return {(sx && b[15]) ? 16'hFFFF : 16'h0, b, (sx && a[15]) ? 16'hFFFF : 16'h0, a};
      end
      2'd1: return {ref_i2f(s[47:32]), ref_i2f(s[15:0])};
      2'd2: return dw ? {s[31:0], s[63:32]} : {s[15:0], s[31:16], s[47:32], s[63:48]};
      default: return 64'h0;
    endcase
  endfunction

  logic        m_valid = 1'b0;
  logic [63:0] m_data = '0;
  string       m_tag = "";

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) m_valid <= 1'b0;
    else if (!m_valid || out_ready) begin
      m_valid <= in_valid;
      if (in_valid) begin
        m_data <= ref_op(in_op, in_data, in_sign_ext, in_dword_swap);
        m_tag  <= cur_tag;
      end
    end
  end

  // back-pressure pattern, moved just after each rising edge
  always @(posedge clk) begin
    #1;
    case (bp_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = (cyc % 5) >= 3;
    endcase
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 in_ready", 64'(in_ready), 64'(!m_valid || out_ready));
      check("R1 out_valid", 64'(out_valid), 64'(m_valid));
      if (m_valid) check(m_tag, out_data, m_data);
    end
  end

  task automatic send(input string tag, input logic [1:0] op, input logic [63:0] d,
                      input logic sx, input logic dw);
    bit ok;
    cur_tag       = tag;
    in_valid      = 1'b1;
    in_op         = op;
    in_data       = d;
    in_sign_ext   = sx;
    in_dword_swap = dw;
    forever begin
      ok = in_ready;
      @(posedge clk);
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic f2i_both(input string tag, input logic [63:0] d);
    send(tag, 2'd0, d, 1'b0, 1'b0);
    send(tag, 2'd0, d, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 out_valid in reset", 64'(out_valid), 64'h0);
    check("R2 in_ready in reset", 64'(in_ready), 64'h1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int pass = 0; pass < 3; pass++) begin
      bp_mode = pass;
      // R3: exact limits and beyond, infinities
      f2i_both("R3 +/-2^15", {32'hC7000000, 32'h47000000});
      f2i_both("R3 just past limits", {32'hC7000080, 32'h47000080});
      f2i_both("R3 infinities", {32'hFF800000, 32'h7F800000});
      // R4: truncation, +/-(2^15-1) and fractions next to the limits
      f2i_both("R4 +/-(2^15-1)", {32'hC6FFFE00, 32'h46FFFE00});
      f2i_both("R4 +/-32767.5", {32'hC6FFFF00, 32'h46FFFF00});
      f2i_both("R4 small values", {32'hBFC00000, 32'h3F400000});
      f2i_both("R4 zero and denormal", {32'h80000000, 32'h00000001});
      f2i_both("R4 100.9 and 1.0", {32'h42C9CCCD, 32'h3F800000});
      // R5: NaN in each lane
      f2i_both("R5 NaN", {32'h7FC00000, 32'hFF800001});
      // R6/R7: negative results exercised in both fill modes above
      send("R6 zero fill negative", 2'd0, {32'hC2C80000, 32'hC0400000}, 1'b0, 1'b0);
      send("R7 sign fill negative", 2'd0, {32'hC2C80000, 32'hC0400000}, 1'b1, 1'b0);
      // R8: int16 to float, upper lane halves carry junk
      send("R8 range ends", 2'd1, 64'hDEAD_8000_BEEF_7FFF, 1'b0, 1'b0);
      send("R8 zero and -1", 2'd1, 64'h1234_0000_5678_FFFF, 1'b1, 1'b1);
      send("R8 1 and 12345", 2'd1, 64'hFFFF_0001_AAAA_3039, 1'b0, 1'b0);
      // R9/R10: permutes
      send("R9 word reverse", 2'd2, 64'h1111_2222_3333_4444, 1'b0, 1'b0);
      send("R10 half exchange", 2'd2, 64'h1111_2222_3333_4444, 1'b1, 1'b1);
      // R11: reserved opcode
      send("R11 reserved", 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    end

    bp_mode = 0;
    repeat (6) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule